// File: doc/BRIEF.md
# UART Interrupt Priority Controller

This block gathers the five interrupt causes of a 16450/16550-style UART into one identification code and one interrupt line. The five causes are receive line errors, received data at or above the trigger level, receive character timeout, transmit holding buffer empty, and modem status change. The serial shifters, FIFOs, baud generator and register decoder sit outside the block. They report to it through single-cycle event pulses, level inputs and decoded register-access strobes.

Each cause has a pending flag of its own, held in the block. A cause that arrives while a more urgent one is being shown is therefore kept, and it is shown once the more urgent one clears. The identification code is evaluated again on every clock from the pending flags and the enable register. When a cause is cleared, or the enables change, the next cause in order appears one clock later. A timeout counter inside the block measures receiver idle time in baud ticks. It starts again whenever a byte enters the receive FIFO or the host reads a byte. It fires after a set number of character times while data is still waiting.

Top module: `uart_irq_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, `iir` reads 8'hC1 and `irq` is low.
- R2: `iir[7:6]` always read 2'b11 and `iir[5:4]` read 2'b00. `iir[3:0]` carries the code: 0001 none, 0110 line error, 0100 received data, 1100 timeout, 0010 holding empty, 0000 modem status. `irq` is high exactly when `iir[0]` is low.
- R3: The enable bits are `ier[0]` for received data and for timeout, `ier[1]` for holding empty, `ier[2]` for line error and `ier[3]` for modem status. `iir` shows the pending cause with enable set that comes first in this order: line error, received data, timeout, holding empty, modem status. If no such cause exists it shows none. The code follows its inputs two clocks after a pending event or level change, and one clock after an `ier` change.
- R4: Received data is pending while `rx_count` is at or above the trigger level. `fcr_trig` picks the level: 0 gives 1, 1 gives FIFO_DEPTH/4, 2 gives FIFO_DEPTH/2 and 3 gives FIFO_DEPTH-2. With the default depth these are 1, 4, 8 and 14.
- R5: While `rx_count` is non-zero, the timeout counter counts `baud_tick` pulses. It starts again at zero on `rx_push` or `rd_rbr`. Timeout becomes pending on the TO_MULT*`char_ticks`-th tick. It never becomes pending while `rx_count` is zero.
- R6: `rd_rbr` clears a pending timeout, and so does `rx_push`.
- R7: `lsr_evt` makes line error pending, and `rd_lsr` clears it.
- R8: `thr_empty_evt` makes holding empty pending. `tx_fifo_reset` also makes it pending, but only while `fifo_mode` is 1; with `fifo_mode` at 0 it has no effect. `wr_thr` clears it.
- R9: `rd_iir` clears holding empty only when `iir` is showing holding empty at the moment of the read. Otherwise holding empty stays pending.
- R10: `msr_evt` makes modem status pending, and `rd_msr` clears it.
- R11: Each pending flag is held on its own, so a lower-priority cause that arrives while a higher one is shown appears once the higher one clears. When a set pulse and its clear strobe land in the same cycle, the flag ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ier | input | 4 | Interrupt enable register value |
| fcr_trig | input | 2 | Receive trigger level select |
| fifo_mode | input | 1 | FIFOs enabled (16550 mode) |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_push | input | 1 | Pulse: byte placed in receive FIFO |
| rd_rbr | input | 1 | Pulse: host read of receive buffer |
| lsr_evt | input | 1 | Pulse: overrun, parity, framing or break flag set |
| rd_lsr | input | 1 | Pulse: host read of line status |
| thr_empty_evt | input | 1 | Pulse: transmit holding buffer went from occupied to empty |
| tx_fifo_reset | input | 1 | Pulse: transmit FIFO reset |
| wr_thr | input | 1 | Pulse: host write of transmit holding register |
| msr_evt | input | 1 | Pulse: modem status delta set |
| rd_msr | input | 1 | Pulse: host read of modem status |
| rd_iir | input | 1 | Pulse: host read of interrupt identification |
| baud_tick | input | 1 | Baud-rate tick strobe |
| char_ticks | input | CHAR_W | Baud ticks per character time |
| iir | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request, active high |

## Verification
The priority logic is tested with every one of the 32 combinations of pending causes, each under all 16 enable values. This sweep shows whether the order is right, whether timeout shares its enable with received data, and whether a masked cause is skipped in favour of the next one down. The trigger compare is swept over every fill count from 0 to 16 at each of the four trigger settings, which pins down each threshold exactly. Directed sequences cover the rest. They count timeout ticks one short of the limit and then up to it, restart the count part way through, clear causes through the access strobes with and without another cause showing, and apply a set pulse and its clear strobe in the same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC   = 5;
  localparam int SRC_LS = 0;
  localparam int SRC_RD = 1;
  localparam int SRC_TO = 2;
  localparam int SRC_TH = 3;
  localparam int SRC_MS = 4;

  typedef enum logic [3:0] {
    IIR_MS   = 4'b0000,
    IIR_NONE = 4'b0001,
    IIR_TH   = 4'b0010,
    IIR_RD   = 4'b0100,
    IIR_LS   = 4'b0110,
    IIR_TO   = 4'b1100
  } iir_code_e;

endpackage

// File: rtl/uart_irq_rx_timeout.sv
module uart_irq_rx_timeout #(
  parameter int CHAR_W  = 6,
  parameter int TO_MULT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              rx_push,
  input  logic              rd_rbr,
  input  logic              fifo_nonempty,
  input  logic              hold,
  input  logic [CHAR_W-1:0] char_ticks,
  output logic              to_evt
);
  localparam int LIM_W = CHAR_W + $clog2(TO_MULT + 1);

  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] limit;
  logic             restart;
  logic             run;

  assign limit   = LIM_W'(TO_MULT) * LIM_W'(char_ticks);
  assign restart = rx_push | rd_rbr;
  assign run     = baud_tick & fifo_nonempty & ~hold & ~restart;
  assign to_evt  = run & ((cnt_q + LIM_W'(1)) >= limit);

  always_ff @(posedge clk) begin
    if (rst || restart || !fifo_nonempty) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= to_evt ? '0 : cnt_q + LIM_W'(1);
    end
  end

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       fcr_trig,
  input  logic             fifo_mode,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rd_rbr,
  input  logic             lsr_evt,
  input  logic             rd_lsr,
  input  logic             thr_empty_evt,
  input  logic             tx_fifo_reset,
  input  logic             wr_thr,
  input  logic             msr_evt,
  input  logic             rd_msr,
  input  logic             rd_iir,
  input  logic             cur_is_th,
  input  logic             to_evt,
  output logic [NSRC-1:0]  pend
);
  localparam logic [CNT_W-1:0] TRG_0 = CNT_W'(1);
  localparam logic [CNT_W-1:0] TRG_1 = CNT_W'(FIFO_DEPTH / 4);
  localparam logic [CNT_W-1:0] TRG_2 = CNT_W'(FIFO_DEPTH / 2);
  localparam logic [CNT_W-1:0] TRG_3 = CNT_W'(FIFO_DEPTH - 2);

  logic [CNT_W-1:0] trig;
  logic             rd_lvl;
  logic [NSRC-1:0]  set_v;
  logic [NSRC-1:0]  clr_v;
  logic [NSRC-1:0]  pend_q;

  always_comb begin
    case (fcr_trig)
      2'd0:    trig = TRG_0;
      2'd1:    trig = TRG_1;
      2'd2:    trig = TRG_2;
      default: trig = TRG_3;
    endcase
  end

  assign rd_lvl = (rx_count >= trig);

  always_comb begin
    set_v         = '0;
    clr_v         = '0;
    set_v[SRC_LS] = lsr_evt;
    clr_v[SRC_LS] = rd_lsr;
    set_v[SRC_RD] = rd_lvl;
    clr_v[SRC_RD] = ~rd_lvl;
    set_v[SRC_TO] = to_evt;
    clr_v[SRC_TO] = rd_rbr | rx_push;
    set_v[SRC_TH] = thr_empty_evt | (tx_fifo_reset & fifo_mode);
    clr_v[SRC_TH] = wr_thr | (rd_iir & cur_is_th);
    set_v[SRC_MS] = msr_evt;
    clr_v[SRC_MS] = rd_msr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        pend_q[i] <= set_v[i] | (pend_q[i] & ~clr_v[i]);
      end
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend,
  input  logic [3:0]      ier,
  output logic [7:0]      iir,
  output logic            irq,
  output logic            cur_is_th
);
  logic [NSRC-1:0] en;
  iir_code_e       code_d;
  iir_code_e       code_q;
  logic            irq_q;

  assign en[SRC_LS] = pend[SRC_LS] & ier[2];
  assign en[SRC_RD] = pend[SRC_RD] & ier[0];
  assign en[SRC_TO] = pend[SRC_TO] & ier[0];
  assign en[SRC_TH] = pend[SRC_TH] & ier[1];
  assign en[SRC_MS] = pend[SRC_MS] & ier[3];

  always_comb begin
    if (en[SRC_LS])      code_d = IIR_LS;
    else if (en[SRC_RD]) code_d = IIR_RD;
    else if (en[SRC_TO]) code_d = IIR_TO;
    else if (en[SRC_TH]) code_d = IIR_TH;
    else if (en[SRC_MS]) code_d = IIR_MS;
    else                 code_d = IIR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= IIR_NONE;
      irq_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      irq_q  <= (code_d != IIR_NONE);
    end
  end

  assign iir       = {4'b1100, code_q};
  assign irq       = irq_q;
  assign cur_is_th = (code_q == IIR_TH);

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  parameter  int CHAR_W     = 6,
  parameter  int TO_MULT    = 4,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        ier,
  input  logic [1:0]        fcr_trig,
  input  logic              fifo_mode,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_push,
  input  logic              rd_rbr,
  input  logic              lsr_evt,
  input  logic              rd_lsr,
  input  logic              thr_empty_evt,
  input  logic              tx_fifo_reset,
  input  logic              wr_thr,
  input  logic              msr_evt,
  input  logic              rd_msr,
  input  logic              rd_iir,
  input  logic              baud_tick,
  input  logic [CHAR_W-1:0] char_ticks,
  output logic [7:0]        iir,
  output logic              irq
);
  logic [NSRC-1:0] pend;
  logic            to_evt;
  logic            cur_is_th;
  logic            fifo_nonempty;

  assign fifo_nonempty = (rx_count != '0);

  uart_irq_rx_timeout #(
    .CHAR_W  (CHAR_W),
    .TO_MULT (TO_MULT)
  ) u_timeout (
    .clk           (clk),
    .rst           (rst),
    .baud_tick     (baud_tick),
    .rx_push       (rx_push),
    .rd_rbr        (rd_rbr),
    .fifo_nonempty (fifo_nonempty),
    .hold          (pend[SRC_TO]),
    .char_ticks    (char_ticks),
    .to_evt        (to_evt)
  );

  uart_irq_sources #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
  ) u_sources (
    .clk           (clk),
    .rst           (rst),
    .fcr_trig      (fcr_trig),
    .fifo_mode     (fifo_mode),
    .rx_count      (rx_count),
    .rx_push       (rx_push),
    .rd_rbr        (rd_rbr),
    .lsr_evt       (lsr_evt),
    .rd_lsr        (rd_lsr),
    .thr_empty_evt (thr_empty_evt),
    .tx_fifo_reset (tx_fifo_reset),
    .wr_thr        (wr_thr),
    .msr_evt       (msr_evt),
    .rd_msr        (rd_msr),
    .rd_iir        (rd_iir),
    .cur_is_th     (cur_is_th),
    .to_evt        (to_evt),
    .pend          (pend)
  );

  uart_irq_prio u_prio (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .ier       (ier),
    .iir       (iir),
    .irq       (irq),
    .cur_is_th (cur_is_th)
  );

endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] ier,
  input logic       fifo_mode,
  input logic       fifo_nonempty,
  input logic       rd_rbr,
  input logic       lsr_evt,
  input logic       rd_lsr,
  input logic       thr_empty_evt,
  input logic       tx_fifo_reset,
  input logic       wr_thr,
  input logic       msr_evt,
  input logic       rd_iir,
  input logic [4:0] pend,
  input logic [7:0] iir,
  input logic       irq
);
  logic any_en;
  assign any_en = (pend[0] & ier[2]) | (pend[1] & ier[0]) | (pend[2] & ier[0]) |
                  (pend[3] & ier[1]) | (pend[4] & ier[3]);

  AST_IRQ_AGREES: assert property (@(posedge clk) disable iff (rst)
    irq == !iir[0]);  // R2
  AST_LS_FIRST: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && ier[2]) |=> (iir[3:0] == 4'h6));  // R3
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (rst)
    !any_en |=> (iir[3:0] == 4'h1));  // R3
  AST_EMPTY_NO_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    (!fifo_nonempty && !pend[2]) |=> !pend[2]);  // R5
  AST_RBR_CLEARS_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    rd_rbr |=> !pend[2]);  // R6
  AST_LSR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_lsr && !lsr_evt) |=> !pend[0]);  // R7
  AST_THR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_thr && !thr_empty_evt && !(tx_fifo_reset && fifo_mode)) |=> !pend[3]);  // R8
  AST_IIR_READ_KEEPS_TH: assert property (@(posedge clk) disable iff (rst)
    (rd_iir && pend[3] && iir[3:0] != 4'h2 && !wr_thr) |=> pend[3]);  // R9
  AST_MSR_LATCH: assert property (@(posedge clk) disable iff (rst)
    msr_evt |=> pend[4]);  // R10

endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .ier           (ier),
  .fifo_mode     (fifo_mode),
  .fifo_nonempty (fifo_nonempty),
  .rd_rbr        (rd_rbr),
  .lsr_evt       (lsr_evt),
  .rd_lsr        (rd_lsr),
  .thr_empty_evt (thr_empty_evt),
  .tx_fifo_reset (tx_fifo_reset),
  .wr_thr        (wr_thr),
  .msr_evt       (msr_evt),
  .rd_iir        (rd_iir),
  .pend          (pend),
  .iir           (iir),
  .irq           (irq)
);

// File: tb/test_uart_irq_arbiter.sv
`timescale 1ns/1ps
module test_uart_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ier = '0;
  logic [1:0] fcr_trig = '0;
  logic       fifo_mode = 1'b0;
  logic [4:0] rx_count = '0;
  logic       rx_push = 1'b0, rd_rbr = 1'b0, lsr_evt = 1'b0, rd_lsr = 1'b0;
  logic       thr_empty_evt = 1'b0, tx_fifo_reset = 1'b0, wr_thr = 1'b0;
  logic       msr_evt = 1'b0, rd_msr = 1'b0, rd_iir = 1'b0, baud_tick = 1'b0;
  logic [5:0] char_ticks = 6'd1;
  logic [7:0] iir;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uart_irq_arbiter i_uart_irq_arbiter (
    .clk(clk), .rst(rst), .ier(ier), .fcr_trig(fcr_trig), .fifo_mode(fifo_mode),
    .rx_count(rx_count), .rx_push(rx_push), .rd_rbr(rd_rbr), .lsr_evt(lsr_evt),
    .rd_lsr(rd_lsr), .thr_empty_evt(thr_empty_evt), .tx_fifo_reset(tx_fifo_reset),
    .wr_thr(wr_thr), .msr_evt(msr_evt), .rd_msr(rd_msr), .rd_iir(rd_iir),
    .baud_tick(baud_tick), .char_ticks(char_ticks), .iir(iir), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [7:0] exp, input string tag);
    logic exp_irq;
    exp_irq = ~exp[0];
    n_chk++;
    if (iir !== exp || irq !== exp_irq) begin
      n_fail++;
      $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b", tag, iir, irq, exp, exp_irq);
    end
  endtask

  task automatic ticks(input int n);
    baud_tick = 1'b1;
    step(n);
    baud_tick = 1'b0;
  endtask

  task automatic clear_all();
    rd_lsr = 1'b1; rd_msr = 1'b1; wr_thr = 1'b1; rd_rbr = 1'b1; rx_count = '0;
    step(1);
    rd_lsr = 1'b0; rd_msr = 1'b0; wr_thr = 1'b0; rd_rbr = 1'b0;
    step(2);
  endtask

  function automatic logic [7:0] exp_iir(input logic [4:0] m, input logic [3:0] e);
    if (m[0] && e[2])      return 8'hC6;
    else if (m[1] && e[0]) return 8'hC4;
    else if (m[2] && e[0]) return 8'hCC;
    else if (m[3] && e[1]) return 8'hC2;
    else if (m[4] && e[3]) return 8'hC0;
    return 8'hC1;
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    step(1);
    check(8'hC1, "R1 during reset");
    step(2);
    rst = 1'b0;
    step(1);
    check(8'hC1, "R1 after reset");

    // R3 and R2: every pending combination against every enable value
    for (int m = 0; m < 32; m++) begin
      ier = '0;
      clear_all();
      fcr_trig = 2'd1;
      char_ticks = 6'd1;
      rx_count = m[1] ? 5'd5 : (m[2] ? 5'd2 : 5'd0);
      lsr_evt = m[0]; thr_empty_evt = m[3]; msr_evt = m[4];
      step(1);
      lsr_evt = 1'b0; thr_empty_evt = 1'b0; msr_evt = 1'b0;
      if (m[2]) ticks(4);
      step(2);
      for (int e = 0; e < 16; e++) begin
        ier = 4'(e);
        step(2);
        check(exp_iir(5'(m), 4'(e)), "R3 priority sweep");
      end
    end

    // R4: trigger thresholds
    ier = 4'b0001;
    clear_all();
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c <= 16; c++) begin
        int trg;
        trg = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
        fcr_trig = 2'(s);
        rx_count = 5'(c);
        step(2);
        check((c >= trg) ? 8'hC4 : 8'hC1, "R4 trigger level");
      end
    end
    rx_count = '0;
    step(2);

    // R5, R6: character timeout, limit 4*3 = 12 ticks
    fcr_trig = 2'd3;
    char_ticks = 6'd3;
    clear_all();
    rx_count = 5'd1;
    rx_push = 1'b1; step(1); rx_push = 1'b0;
    ticks(11); step(2);
    check(8'hC1, "R5 one tick short");
    ticks(1); step(2);
    check(8'hCC, "R5 timeout fires");
    rd_rbr = 1'b1; step(1); rd_rbr = 1'b0; step(2);
    check(8'hC1, "R6 rbr read clears timeout");
    ticks(8);
    rx_push = 1'b1; step(1); rx_push = 1'b0;
    ticks(11); step(2);
    check(8'hC1, "R5 push restarts count");
    ticks(1); step(2);
    check(8'hCC, "R5 fires after restart");
    rx_push = 1'b1; step(1); rx_push = 1'b0; step(2);
    check(8'hC1, "R6 push clears timeout");
    rx_count = '0;
    step(1);
    ticks(30); step(2);
    check(8'hC1, "R5 empty fifo never times out");

    // R7, R10, R11
    ier = 4'hF;
    clear_all();
    lsr_evt = 1'b1; step(1); lsr_evt = 1'b0; step(2);
    check(8'hC6, "R7 line error raised");
    msr_evt = 1'b1; step(1); msr_evt = 1'b0; step(2);
    check(8'hC6, "R11 modem held behind line error");
    rd_lsr = 1'b1; step(1); rd_lsr = 1'b0; step(2);
    check(8'hC0, "R11 modem shown after lsr read");
    rd_msr = 1'b1; step(1); rd_msr = 1'b0; step(2);
    check(8'hC1, "R10 msr read clears");
    lsr_evt = 1'b1; rd_lsr = 1'b1; step(1); lsr_evt = 1'b0; rd_lsr = 1'b0; step(2);
    check(8'hC6, "R11 set wins over clear");
    rd_lsr = 1'b1; step(1); rd_lsr = 1'b0; step(2);
    check(8'hC1, "R7 lsr read clears");

    // R8, R9
    thr_empty_evt = 1'b1; step(1); thr_empty_evt = 1'b0; step(2);
    check(8'hC2, "R8 holding empty raised");
    wr_thr = 1'b1; step(1); wr_thr = 1'b0; step(2);
    check(8'hC1, "R8 thr write clears");
    fifo_mode = 1'b0;
    tx_fifo_reset = 1'b1; step(1); tx_fifo_reset = 1'b0; step(2);
    check(8'hC1, "R8 tx reset ignored outside fifo mode");
    fifo_mode = 1'b1;
    tx_fifo_reset = 1'b1; step(1); tx_fifo_reset = 1'b0; step(2);
    check(8'hC2, "R8 tx reset raises in fifo mode");
    msr_evt = 1'b1; step(1); msr_evt = 1'b0; step(2);
    check(8'hC2, "R11 holding empty over modem");
    rd_iir = 1'b1; step(1); rd_iir = 1'b0; step(2);
    check(8'hC0, "R9 iir read clears shown holding empty");
    thr_empty_evt = 1'b1; step(1); thr_empty_evt = 1'b0; step(2);
    lsr_evt = 1'b1; step(1); lsr_evt = 1'b0; step(2);
    check(8'hC6, "R7 line error over holding empty");
    rd_iir = 1'b1; step(1); rd_iir = 1'b0; step(2);
    check(8'hC6, "R9 iir read leaves line error");
    rd_lsr = 1'b1; step(1); rd_lsr = 1'b0; step(2);
    check(8'hC2, "R9 holding empty kept when not shown");
    rd_msr = 1'b1; wr_thr = 1'b1; step(1); rd_msr = 1'b0; wr_thr = 1'b0; step(2);
    check(8'hC1, "R10 all cleared");

    finish_up();
  end

endmodule